// File: doc/BRIEF.md
# Instruction Boundary Chainer

This block finds where variable-length instructions begin inside a 32-byte fetch window. An earlier stage has already worked out, for every byte position of the window, how long an instruction would be if one started there (1 to 15 bytes). Each byte position has such a length, whether or not an instruction really starts there. Starting from a held start offset, the block follows those lengths from one instruction to the next. In a single cycle it marks out up to eight consecutive instructions. For each slot it reports a valid flag, a start offset and a length. It also reports how many bytes were used, so that the window can be shifted by whole bytes for the next cycle.

The window carries a count of the bytes that are present. A slot is delivered only if its whole instruction lies inside that count. A length of zero on the chain is illegal: it stops the chain and raises an error flag. A fixed-width mode treats every instruction as four bytes long and ignores the length inputs.

The result is registered and offered with a valid/ready handshake. The control is a two-state machine:
- `S_IDLE`: no result is held.
- `S_HOLD`: a result is on the outputs.

The transitions are:
- `fill` (`S_IDLE` to `S_HOLD`): a window arrives.
- `stall` (`S_HOLD` to `S_HOLD`): the consumer is not ready.
- `stream` (`S_HOLD` to `S_HOLD`): the result is accepted and a new window arrives in the same cycle.
- `drain` (`S_HOLD` to `S_IDLE`): the result is accepted and no window arrives.
- `reload` (any state to `S_IDLE`): the start offset is loaded.

Top module: `insn_boundary_sel`

## Requirements
- R1: After reset, `out_valid` is 0 and the held start offset is 0.
- R2: When slot 0 is valid, its start equals the held start offset. Its length is the per-byte length at that offset, where the length for byte b is `win_len[4*b+3:4*b]`.
- R3: Each later valid slot starts at the previous slot's start plus the previous slot's length.
- R4: At most eight slots are valid. `consumed` is the sum of the lengths of the valid slots, and it is 0 exactly when slot 0 is invalid.
- R5: A slot is valid only if it starts below `win_count` and its start plus its length is at most `win_count`. The first slot that fails this test is invalid, and so is every slot after it. An invalid slot reports a start and a length of 0.
- R6: A length of 0 at a present byte that the chain reaches sets `err_zero`. That slot and all later slots are invalid.
- R7: When `fixed_mode` is 1, every instruction is 4 bytes long and the `win_len` values have no effect, including zeros.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady. When the result is accepted, the start offset advances by `consumed`, and only then.
- R9: `start_load` writes `start_in` into the start offset and drops any held result on the next cycle.
- R10: The valid slots always form a prefix: slot k is valid only if slots 0 to k-1 are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_load | input | 1 | Load `start_in` as the start offset |
| start_in | input | 5 | New start offset |
| win_valid | input | 1 | A window is presented |
| win_count | input | 6 | Number of bytes present (0 to 32) |
| win_len | input | 128 | 4-bit length for each byte offset, byte b at bits 4b+3:4b |
| fixed_mode | input | 1 | 1: every instruction is 4 bytes long |
| out_ready | input | 1 | The consumer accepts the held result |
| out_valid | output | 1 | A result is held |
| slot_valid | output | 8 | Valid flag for each slot |
| slot_start | output | 40 | 5-bit start offset for each slot, slot k at bits 5k+4:5k |
| slot_len | output | 32 | 4-bit length for each slot, slot k at bits 4k+3:4k |
| consumed | output | 6 | Bytes used by the valid slots |
| err_zero | output | 1 | A zero length stopped the chain |

## Verification
The chain is tried with several length patterns:
- A uniform length fills all eight slots and shows the plain stepping of the chain.
- A mixed pattern started from an odd offset shows that each slot reads the length at its own start, not at a fixed slot position.
- A shortened window count shows where the chain stops on a fit failure.
- A start beyond the count shows that a byte which is not present gives neither a slot nor an error.
- A zero length placed mid-chain separates the error stop from the fit stop.
- Garbage lengths in fixed-width mode show that the lengths are ignored.

Stalled and back-to-back accepts show that the start offset moves only when a result is accepted.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } ibs_state_e;
endpackage

// File: rtl/ibs_len_pick.sv
// Selects the precomputed length stored for one byte offset; 0 when the
// offset lies past the end of the window.
module ibs_len_pick #(
    parameter int WIN_BYTES = 32,
    parameter int LEN_W     = 4,
    parameter int POS_W     = 7,
    localparam int OFF_W    = $clog2(WIN_BYTES)
) (
    input  logic [WIN_BYTES*LEN_W-1:0] win_len,
    input  logic [POS_W-1:0]           pos,
    output logic [LEN_W-1:0]           len_o
);
    logic [OFF_W-1:0] idx;

    always_comb begin
        idx   = pos[OFF_W-1:0];
        len_o = '0;
        if (pos < POS_W'(WIN_BYTES)) begin
            len_o = win_len[idx*LEN_W +: LEN_W];
        end
    end
endmodule

// File: rtl/ibs_chain.sv
// Serial boundary chain: slot k+1 begins where slot k ends.
module ibs_chain #(
    parameter int WIN_BYTES = 32,
    parameter int SLOTS     = 8,
    parameter int LEN_W     = 4,
    parameter int FIXED_LEN = 4,
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int CNT_W    = $clog2(WIN_BYTES + 1),
    localparam int POS_W    = CNT_W + 1
) (
    input  logic [WIN_BYTES*LEN_W-1:0] win_len,
    input  logic [CNT_W-1:0]           win_count,
    input  logic [CNT_W-1:0]           start,
    input  logic                       fixed_mode,
    output logic [SLOTS-1:0]           slot_valid,
    output logic [SLOTS*OFF_W-1:0]     slot_start,
    output logic [SLOTS*LEN_W-1:0]     slot_len,
    output logic [CNT_W-1:0]           consumed,
    output logic                       err_zero
);
    logic [POS_W-1:0] pos   [SLOTS+1];
    logic             alive [SLOTS+1];
    logic [SLOTS-1:0] zero_hit;

    assign pos[0]   = POS_W'(start);
    assign alive[0] = 1'b1;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [LEN_W-1:0] picked;
        logic [LEN_W-1:0] len_eff;
        logic             present;
        logic             fits;
        logic             ok;

        ibs_len_pick #(
            .WIN_BYTES(WIN_BYTES),
            .LEN_W    (LEN_W),
            .POS_W    (POS_W)
        ) u_pick (
            .win_len(win_len),
            .pos    (pos[k]),
            .len_o  (picked)
        );

        always_comb begin
            len_eff     = fixed_mode ? LEN_W'(FIXED_LEN) : picked;
            present     = pos[k] < POS_W'(win_count);
            fits        = (pos[k] + POS_W'(len_eff)) <= POS_W'(win_count);
            ok          = alive[k] && present && (len_eff != '0) && fits;
            zero_hit[k] = alive[k] && present && (len_eff == '0);
        end

        assign alive[k+1] = ok;
        assign pos[k+1]   = ok ? pos[k] + POS_W'(len_eff) : pos[k];

        assign slot_valid[k]                = ok;
        assign slot_start[k*OFF_W +: OFF_W] = ok ? pos[k][OFF_W-1:0] : '0;
        assign slot_len[k*LEN_W +: LEN_W]   = ok ? len_eff : '0;
    end

    assign consumed = CNT_W'(pos[SLOTS] - pos[0]);
    assign err_zero = |zero_hit;
endmodule

// File: rtl/insn_boundary_sel.sv
module insn_boundary_sel
    import ibs_pkg::*;
#(
    parameter int WIN_BYTES = 32,
    parameter int SLOTS     = 8,
    parameter int LEN_W     = 4,
    parameter int FIXED_LEN = 4,
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_load,
    input  logic [OFF_W-1:0]           start_in,
    input  logic                       win_valid,
    input  logic [CNT_W-1:0]           win_count,
    input  logic [WIN_BYTES*LEN_W-1:0] win_len,
    input  logic                       fixed_mode,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [SLOTS-1:0]           slot_valid,
    output logic [SLOTS*OFF_W-1:0]     slot_start,
    output logic [SLOTS*LEN_W-1:0]     slot_len,
    output logic [CNT_W-1:0]           consumed,
    output logic                       err_zero
);
    ibs_state_e state_q, state_d;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] start_eff;
    logic             accept;
    logic             take;

    logic [SLOTS-1:0]       c_valid;
    logic [SLOTS*OFF_W-1:0] c_start;
    logic [SLOTS*LEN_W-1:0] c_len;
    logic [CNT_W-1:0]       c_cons;
    logic                   c_err;

    assign accept    = (state_q == S_HOLD) && out_ready;
    assign take      = win_valid && ((state_q == S_IDLE) || accept);
    assign start_eff = accept ? start_q + consumed : start_q;

    ibs_chain #(
        .WIN_BYTES(WIN_BYTES),
        .SLOTS    (SLOTS),
        .LEN_W    (LEN_W),
        .FIXED_LEN(FIXED_LEN)
    ) u_chain (
        .win_len   (win_len),
        .win_count (win_count),
        .start     (start_eff),
        .fixed_mode(fixed_mode),
        .slot_valid(c_valid),
        .slot_start(c_start),
        .slot_len  (c_len),
        .consumed  (c_cons),
        .err_zero  (c_err)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = take ? S_HOLD : S_IDLE;
            S_HOLD: begin
                if (accept) state_d = take ? S_HOLD : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (start_load) state_d = S_IDLE;
    end

    // state and start offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_load)  start_q <= CNT_W'(start_in);
            else if (accept) start_q <= start_eff;
        end
    end

    // registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_valid <= '0;
            slot_start <= '0;
            slot_len   <= '0;
            consumed   <= '0;
            err_zero   <= 1'b0;
        end else if (!start_load && take) begin
            slot_valid <= c_valid;
            slot_start <= c_start;
            slot_len   <= c_len;
            consumed   <= c_cons;
            err_zero   <= c_err;
        end
    end

    assign out_valid = (state_q == S_HOLD);
endmodule

// File: rtl/ibs_chk.sv
module ibs_chk #(
    parameter int SLOTS = 8,
    parameter int OFF_W = 5,
    parameter int CNT_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_load,
    input logic [OFF_W-1:0]       start_in,
    input logic                   out_ready,
    input logic                   out_valid,
    input logic [SLOTS-1:0]       slot_valid,
    input logic [SLOTS*OFF_W-1:0] slot_start,
    input logic [CNT_W-1:0]       consumed,
    input logic                   err_zero,
    input logic [CNT_W-1:0]       start_q
);
    a_r10_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((slot_valid & (slot_valid + SLOTS'(1))) == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start_load |=>
            out_valid && $stable(slot_valid) && $stable(slot_start) && $stable(consumed));

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !start_load |=>
            start_q == CNT_W'($past(start_q) + $past(consumed)));

    a_r6_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && err_zero |-> !slot_valid[SLOTS-1]);

    a_r2_slot0_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && slot_valid[0] |-> slot_start[OFF_W-1:0] == start_q[OFF_W-1:0]);

    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> !out_valid && start_q == CNT_W'($past(start_in)));

    a_r4_cons_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((consumed == '0) == !slot_valid[0]));
endmodule

bind insn_boundary_sel ibs_chk #(
    .SLOTS(SLOTS),
    .OFF_W(OFF_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_load(start_load),
    .start_in  (start_in),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .slot_valid(slot_valid),
    .slot_start(slot_start),
    .consumed  (consumed),
    .err_zero  (err_zero),
    .start_q   (start_q)
);

// File: tb/insn_boundary_sel_bench.sv
`timescale 1ns/1ps
module insn_boundary_sel_bench;
    localparam int WB = 32;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_load = 1'b0;
    logic [4:0]    start_in = '0;
    logic          win_valid = 1'b0;
    logic [5:0]    win_count = '0;
    logic [127:0]  win_len = '0;
    logic          fixed_mode = 1'b0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [7:0]    slot_valid;
    logic [39:0]   slot_start;
    logic [31:0]   slot_len;
    logic [5:0]    consumed;
    logic          err_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int exp_start = 0;

    logic [7:0]  e_valid;
    logic [39:0] e_start;
    logic [31:0] e_len;
    int          e_cons;
    logic        e_err;

    always #4 clk = ~clk;

    insn_boundary_sel u_insn_boundary_sel (
        .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_in(start_in),
        .win_valid(win_valid), .win_count(win_count), .win_len(win_len),
        .fixed_mode(fixed_mode), .out_ready(out_ready), .out_valid(out_valid),
        .slot_valid(slot_valid), .slot_start(slot_start), .slot_len(slot_len),
        .consumed(consumed), .err_zero(err_zero)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected result from the requirements (R2..R7)
    task automatic model(input int start);
        int  pos;
        bit  alive;
        pos = start; alive = 1; e_valid = '0; e_start = '0; e_len = '0; e_err = 0;
        for (int k = 0; k < NS; k++) begin
            int l;
            bit present, ok;
            present = pos < int'(win_count);
            l = fixed_mode ? 4 : (pos < WB ? int'(win_len[pos*4 +: 4]) : 0);
            ok = alive && present && l != 0 && (pos + l) <= int'(win_count);
            if (alive && present && l == 0) e_err = 1;
            if (ok) begin
                e_valid[k] = 1'b1;
                e_start[k*5 +: 5] = 5'(pos);
                e_len[k*4 +: 4] = 4'(l);
                pos += l;
            end
            alive = ok;
        end
        e_cons = pos - start;
    endtask

    task automatic check_out(input string req);
        model(exp_start);
        chk(out_valid === 1'b1, {req, " out_valid"}, out_valid, 1);
        chk(slot_valid === e_valid, {req, " slot_valid"}, slot_valid, e_valid);
        chk(slot_start === e_start, {req, " slot_start"}, slot_start, e_start);
        chk(slot_len === e_len, {req, " slot_len"}, slot_len, e_len);
        chk(int'(consumed) == e_cons, {req, " consumed"}, consumed, e_cons);
        chk(err_zero === e_err, {req, " err_zero"}, err_zero, e_err);
    endtask

    task automatic load_start(input int s);
        @(negedge clk); start_load = 1; start_in = 5'(s); out_ready = 0; win_valid = 0;
        @(negedge clk); start_load = 0;
        exp_start = s;
    endtask

    task automatic present_and_check(input string req);
        @(negedge clk); win_valid = 1;
        @(posedge clk); #1;
        check_out(req);
        @(negedge clk); win_valid = 0; out_ready = 1;
        exp_start += e_cons;
        @(negedge clk); out_ready = 0;
    endtask

    task automatic fill_len(input int l);
        for (int b = 0; b < WB; b++) win_len[b*4 +: 4] = 4'(l);
    endtask

    task automatic t_reset;  // R1
        chk(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
        present_and_check("R1 start offset 0 after reset");
        chk(slot_start[4:0] == 0 && exp_start == 24, "R1 start 0", slot_start[4:0], 0);
    endtask

    task automatic t_uniform;  // R2 R3 R4
        load_start(0); fixed_mode = 0; win_count = 32; fill_len(3);
        present_and_check("R3 uniform length 3");
        chk(e_valid == 8'hFF && e_cons == 24, "R4 eight slots", e_cons, 24);
    endtask

    task automatic t_mixed;  // R2 R3
        load_start(5); win_count = 32; fill_len(9);
        win_len[5*4 +: 4] = 2; win_len[7*4 +: 4] = 1; win_len[8*4 +: 4] = 3;
        win_len[11*4 +: 4] = 4; win_len[15*4 +: 4] = 1; win_len[16*4 +: 4] = 2;
        win_len[18*4 +: 4] = 5; win_len[23*4 +: 4] = 1;
        present_and_check("R2 mixed lengths from offset 5");
        chk(e_cons == 19, "R3 mixed consumed", e_cons, 19);
    endtask

    task automatic t_fit;  // R5
        load_start(0); win_count = 20; fill_len(6);
        present_and_check("R5 fit against count 20");
        chk(e_valid == 8'h07, "R5 three slots fit", e_valid, 8'h07);
        load_start(25);
        present_and_check("R5 start beyond count");
    endtask

    task automatic t_zero;  // R6
        load_start(0); win_count = 32; fill_len(7);
        win_len[14*4 +: 4] = 0;
        present_and_check("R6 zero length mid chain");
        chk(e_err == 1 && e_valid == 8'h03, "R6 error stops chain", e_valid, 8'h03);
    endtask

    task automatic t_fixed;  // R7
        load_start(0); win_count = 32; fill_len(0); win_len[4*4 +: 4] = 11;
        fixed_mode = 1;
        present_and_check("R7 fixed mode ignores lengths");
        chk(e_cons == 32 && e_err == 0, "R7 fixed consumed 32", e_cons, 32);
        fixed_mode = 0;
    endtask

    task automatic t_handshake;  // R8 R9
        load_start(0); win_count = 32; fill_len(2);
        @(negedge clk); win_valid = 1;
        @(posedge clk); #1; check_out("R8 first result");
        @(negedge clk); fill_len(5);
        @(posedge clk); #1;
        fill_len(2);
        check_out("R8 held while not ready");
        @(negedge clk); out_ready = 1;
        exp_start += e_cons;
        @(posedge clk); #1; check_out("R8 advanced by consumed");
        chk(exp_start == 16, "R8 start 16", exp_start, 16);
        @(negedge clk); out_ready = 0; win_valid = 0; start_load = 1; start_in = 3;
        @(posedge clk); #1;
        chk(out_valid === 1'b0, "R9 load drops result", out_valid, 0);
        @(negedge clk); start_load = 0; exp_start = 3;
        present_and_check("R9 chain from loaded start");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre: chk(out_valid === 1'b0, "R1 in reset", out_valid, 0);
        @(negedge clk); rst_n = 1; win_count = 32; fill_len(3);
        t_reset();
        t_uniform();
        t_mixed();
        t_fit();
        t_zero();
        t_fixed();
        t_handshake();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule